// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port

This block is an 8-bit, full-duplex serial shift port for a small microcontroller. Software first writes a control register that sets the shift clock source, the prescaler ratio, the bit order and the pin routing. It then writes the data register. Each bit goes out on the data-out pin while a bit is taken in from the data-in pin, and both use one shared shift clock. After eight bits a 3-bit counter ends the transfer. The port then raises a one-cycle interrupt request, and the data register holds the received byte.

The shift clock has two possible sources. The first is an internal prescaler that divides the system clock by 8, 16, 32, 64, 128 or 256; in that case a data write starts the transfer at once. The second is an external clock pin, synchronized into the system clock domain; in that case a data write only arms the port, and the external clock edges drive the shift. Output data changes on the falling edge of the shift clock and input data is sampled on the rising edge. The shift clock idles high.

The pin routing is given as enable and mode outputs. Data-out can drive as a push-pull output or as an open-drain output. The generated clock can go to either of two pins, and the pin that is not selected stays with general I/O.

Top module: `sync_serial_port`

## Requirements
- R1: After reset both registers read 0, `sclk_out` is 1, `irq` and `busy` are 0, and `sdo_oe`, `sclk_a_oe` and `sclk_b_oe` are 0.
- R2: Control bits 2..0 select the internal ratio N: 000→8, 001→16, 010→32, 011→64, 110→128, 111→256. With the internal clock, `irq` is high in exactly the cycle that follows the clock edge that is 8·N cycles after the edge that accepts the data write.
- R3: Control bit 6 = 1 selects the internal clock. A data write (`wr_addr`=0) starts shifting at once. `sclk_out` first falls N/2 cycles after the write and stays high once eight rising edges have occurred.
- R4: A transfer is full duplex. `sdo` changes only on a falling shift-clock edge, `sdi` is sampled on the rising edge, and after completion a read at address 0 returns the eight received bits.
- R5: Control bit 5 = 0 sends and receives LSB first; bit 5 = 1 sends and receives MSB first.
- R6: Control bit 6 = 0 selects the external clock. A data write then only arms the port: `busy` goes to 1, and until `sclk_in` toggles there is no shifting and no `irq`.
- R7: With the external clock, eight rising edges of `sclk_in` complete the transfer, and the same falling/rising data timing applies.
- R8: Each completed transfer gives one `irq` pulse that lasts exactly one cycle, and `busy` is 0 while `irq` is high.
- R9: Control bit 3 = 0 leaves all pins to general I/O, with every enable at 0. Bit 3 = 1 enables `sdo`. With the internal clock the clock is driven on pin A when bit 7 = 0 and on pin B when bit 7 = 1. With the external clock neither clock pin is enabled.
- R10: Control bit 4 = 1 selects open-drain data-out. `sdo_od` is then 1 and `sdo_oe` is 1 only while the data-out bit is 0.
- R11: A read at address 1 returns the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 data, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read target: 0 data, 1 control |
| rd_data | output | 8 | Read data |
| sclk_in | input | 1 | External shift clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Data-out pin drive enable |
| sdo_od | output | 1 | Data-out pin in open-drain mode |
| sclk_out | output | 1 | Generated shift clock |
| sclk_a_oe | output | 1 | Clock drive enable, pin A |
| sclk_b_oe | output | 1 | Clock drive enable, pin B |
| busy | output | 1 | Transfer running or armed |
| irq | output | 1 | Transfer-complete request, one cycle |

## Verification
The assertions assume three things about the inputs. The control register is not rewritten while a transfer runs. The reserved ratio codes are never written. The external clock is slow enough that each of its levels lasts several system cycles, which the two-stage synchronizer needs in order to see every edge. The bench writes control only while the port is idle and uses only the six legal ratio codes. It toggles `sclk_in` with six-cycle half periods, keeps it high at every data write, and changes `sdi` only just after a falling clock edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DATA_W    = 8;
  localparam int BASE_HALF = 4;
  localparam int DIV_W     = 7;

  typedef struct packed {
    logic       pin_b;
    logic       clk_int;
    logic       msb_first;
    logic       open_drain;
    logic       port_en;
    logic [2:0] div_code;
  } ssp_ctrl_t;

  function automatic logic [DIV_W-1:0] half_m1(input logic [2:0] code);
    logic [2:0] idx;
    idx = code[2] ? {2'b10, code[0]} : {1'b0, code[1:0]};
    return DIV_W'((BASE_HALF << idx) - 1);
  endfunction
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ssp_prescaler.sv
module ssp_prescaler #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = run && !clear && (cnt_q == limit);

  always_comb begin
    cnt_n = cnt_q;
    if (clear || !run)   cnt_n = '0;
    else if (tick)       cnt_n = '0;
    else                 cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         msb_first,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         sin,
  output logic [W-1:0] dout,
  output logic         sout,
  output logic         active,
  output logic         done
);
  localparam int          CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q, sr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;
  logic          out_q, out_n;
  logic          done_q, done_n;

  always_comb begin
    sr_n   = sr_q;
    cnt_n  = cnt_q;
    act_n  = act_q;
    out_n  = out_q;
    done_n = 1'b0;
    if (start) begin
      sr_n  = load;
      cnt_n = '0;
      act_n = 1'b1;
    end else if (act_q) begin
      if (fall_ev) out_n = msb_first ? sr_q[W-1] : sr_q[0];
      if (rise_ev) begin
        sr_n  = msb_first ? {sr_q[W-2:0], sin} : {sin, sr_q[W-1:1]};
        cnt_n = cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          act_n  = 1'b0;
          done_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      out_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      out_q  <= out_n;
      done_q <= done_n;
    end
  end

  assign dout   = sr_q;
  assign sout   = out_q;
  assign active = act_q;
  assign done   = done_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          sclk_in,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          sdo_od,
  output logic          sclk_out,
  output logic          sclk_a_oe,
  output logic          sclk_b_oe,
  output logic          busy,
  output logic          irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // control register
  ssp_ctrl_t ctrl_q, ctrl_n;
  logic      ctrl_we, start;
  assign ctrl_we = wr_en && wr_addr;
  assign start   = wr_en && !wr_addr;

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_we) ctrl_n = ssp_ctrl_t'(wr_data[7:0]);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ctrl_q <= '0;
    else        ctrl_q <= ctrl_n;
  end

  logic ctrl_int;
  assign ctrl_int = ctrl_q.clk_int;

  // internal clock generation
  logic active, tick;
  logic sclk_q, sclk_n;

  ssp_prescaler #(.CW(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (active && ctrl_int),
    .clear (start),
    .limit (half_m1(ctrl_q.div_code)),
    .tick  (tick)
  );

  always_comb begin
    sclk_n = sclk_q;
    if (start)                    sclk_n = 1'b1;
    else if (ctrl_int && tick)    sclk_n = !sclk_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sclk_q <= 1'b1;
    else        sclk_q <= sclk_n;
  end

  // external clock and data, synchronized together
  logic [1:0] ext_s;
  logic       ext_prev_q;

  ssp_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({sclk_in, sdi}),
    .q     (ext_s)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ext_prev_q <= 1'b1;
    else        ext_prev_q <= ext_s[1];
  end

  // edge selection
  logic fall_ev, rise_ev, sin_bit;
  always_comb begin
    if (ctrl_int) begin
      fall_ev = tick && sclk_q;
      rise_ev = tick && !sclk_q;
      sin_bit = sdi;
    end else begin
      fall_ev = ext_prev_q && !ext_s[1];
      rise_ev = !ext_prev_q && ext_s[1];
      sin_bit = ext_s[0];
    end
  end

  logic [DW-1:0] sr;
  logic          sout;

  ssp_shifter #(.W(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_i),
    .start     (start),
    .load      (wr_data),
    .msb_first (ctrl_q.msb_first),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .sin       (sin_bit),
    .dout      (sr),
    .sout      (sout),
    .active    (active),
    .done      (irq)
  );

  // pin routing
  assign sdo       = sout;
  assign sdo_od    = ctrl_q.port_en && ctrl_q.open_drain;
  assign sdo_oe    = ctrl_q.port_en && (!ctrl_q.open_drain || !sout);
  assign sclk_out  = sclk_q;
  assign sclk_a_oe = ctrl_q.port_en && ctrl_int && !ctrl_q.pin_b;
  assign sclk_b_oe = ctrl_q.port_en && ctrl_int && ctrl_q.pin_b;
  assign busy      = active;
  assign rd_data   = rd_addr ? DW'(ctrl_q) : sr;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic busy,
  input logic sclk_out,
  input logic sdo,
  input logic sclk_a_oe,
  input logic sclk_b_oe,
  input logic clk_int
);
  // R8: request is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8: completion coincides with the port going idle
  a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  // R9: at most one clock pin is driven
  a_r9_one_clk_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_a_oe && sclk_b_oe));

  // R3: the shift clock rests high whenever no transfer runs
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);

  // R4: with the internal clock, data-out holds while the clock stays high
  a_r4_sdo_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_int && busy && $past(busy) && sclk_out && $past(sclk_out)) |-> $stable(sdo));

  // R6: with the external clock, the generated clock never toggles
  a_r6_ext_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_int && $past(!clk_int)) |-> $stable(sclk_out));
endmodule

bind sync_serial_port ssp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_i),
  .irq       (irq),
  .busy      (busy),
  .sclk_out  (sclk_out),
  .sdo       (sdo),
  .sclk_a_oe (sclk_a_oe),
  .sclk_b_oe (sclk_b_oe),
  .clk_int   (ctrl_int)
);

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       sclk_in = 1'b1;
  logic       sdi = 1'b0;
  logic       sdo, sdo_oe, sdo_od, sclk_out, sclk_a_oe, sclk_b_oe, busy, irq;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;

  always #4 clk = ~clk;

  sync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sclk_in(sclk_in), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdo_od(sdo_od), .sclk_out(sclk_out),
    .sclk_a_oe(sclk_a_oe), .sclk_b_oe(sclk_b_oe), .busy(busy), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input bit addr, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit addr, output logic [7:0] v);
    rd_addr = addr;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v0, v1;
    rd(1'b0, v0);
    rd(1'b1, v1);
    chk(v0 == 8'h00 && v1 == 8'h00, "R1", "registers after reset", {v1, v0}, 0);
    chk(sclk_out && !irq && !busy, "R1", "clk/irq/busy after reset",
        {sclk_out, irq, busy}, 3'b100);
    chk(!sdo_oe && !sclk_a_oe && !sclk_b_oe, "R1", "enables after reset",
        {sdo_oe, sclk_a_oe, sclk_b_oe}, 0);
  endtask

  task automatic t_pinmux();
    logic [7:0] v;
    bus_wr(1'b1, 8'h40);
    chk({sdo_oe, sclk_a_oe, sclk_b_oe} == 3'b000, "R9", "port off", {sdo_oe, sclk_a_oe, sclk_b_oe}, 0);
    bus_wr(1'b1, 8'h48);
    chk({sdo_oe, sclk_a_oe, sclk_b_oe} == 3'b110, "R9", "pin A", {sdo_oe, sclk_a_oe, sclk_b_oe}, 3'b110);
    bus_wr(1'b1, 8'hC8);
    chk({sdo_oe, sclk_a_oe, sclk_b_oe} == 3'b101, "R9", "pin B", {sdo_oe, sclk_a_oe, sclk_b_oe}, 3'b101);
    bus_wr(1'b1, 8'h08);
    chk({sdo_oe, sclk_a_oe, sclk_b_oe} == 3'b100, "R9", "external clock", {sdo_oe, sclk_a_oe, sclk_b_oe}, 3'b100);
    bus_wr(1'b1, 8'h58);
    chk(sdo_od && !sdo_oe && sdo, "R10", "open drain, high bit released",
        {sdo_od, sdo_oe, sdo}, 3'b101);
    rd(1'b1, v);
    chk(v == 8'h58, "R11", "control readback", v, 8'h58);
  endtask

  task automatic t_int(input logic [2:0] code, input bit msb, input bit od,
                       input logic [7:0] tx, input logic [7:0] rxv);
    int n, cnt, irq_at, irq_len, fi, ri;
    logic [7:0] got, exp_sdo, v;
    bit prev, fall_ok;
    n = 8 << (code[2] ? (code[0] ? 5 : 4) : int'(code[1:0]));
    bus_wr(1'b1, {1'b0, 1'b1, msb, od, 1'b1, code});
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = tx;
    @(negedge clk);
    wr_en = 1'b0;
    cnt = 0; irq_at = -1; irq_len = 0; fi = 0; ri = 0; got = '0;
    prev = sclk_out;
    fall_ok = 1'b1;
    while (cnt < 8 * n + 3) begin
      @(negedge clk);
      cnt++;
      if (prev && !sclk_out) begin
        if (fi == 0 && cnt != n / 2) fall_ok = 1'b0;
        sdi = msb ? rxv[7 - fi] : rxv[fi];
        fi++;
      end
      if (!prev && sclk_out) begin
        got[ri] = sdo;
        ri++;
      end
      if (irq) begin
        if (irq_at < 0) irq_at = cnt;
        irq_len++;
      end
      prev = sclk_out;
    end
    for (int i = 0; i < 8; i++) exp_sdo[i] = msb ? tx[7 - i] : tx[i];
    chk(irq_at == 8 * n, "R2", "irq cycle after write", irq_at, 8 * n);
    chk(fall_ok && fi == 8 && ri == 8 && sclk_out && !busy, "R3",
        "start timing, edge count, stop high", {fi, ri}, 16'h0808);
    chk(got == exp_sdo, msb ? "R5" : "R4", "sdo bit sequence", got, exp_sdo);
    rd(1'b0, v);
    chk(v == rxv, msb ? "R5" : "R4", "received byte", v, rxv);
    chk(irq_len == 1, "R8", "irq pulse width", irq_len, 1);
    if (od) chk(sdo_oe == !exp_sdo[7], "R10", "open drain drive on last bit", sdo_oe, !exp_sdo[7]);
  endtask

  task automatic t_ext(input bit msb, input logic [7:0] tx, input logic [7:0] rxv);
    int base;
    logic [7:0] got, exp_sdo, v;
    sclk_in = 1'b1;
    bus_wr(1'b1, {1'b0, 1'b0, msb, 1'b0, 1'b1, 3'b000});
    base = irq_cnt;
    bus_wr(1'b0, tx);
    repeat (40) @(negedge clk);
    rd(1'b0, v);
    chk(busy && irq_cnt == base && v == tx && sclk_out, "R6",
        "armed without clock", {busy, v}, {1'b1, tx});
    chk(!sclk_a_oe && !sclk_b_oe, "R9", "no clock pin in external mode",
        {sclk_a_oe, sclk_b_oe}, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sclk_in = 1'b0;
      sdi = msb ? rxv[7 - i] : rxv[i];
      repeat (6) @(negedge clk);
      got[i] = sdo;
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) exp_sdo[i] = msb ? tx[7 - i] : tx[i];
    chk(irq_cnt == base + 1 && !busy, "R7", "single completion", irq_cnt - base, 1);
    chk(got == exp_sdo, "R7", "external sdo sequence", got, exp_sdo);
    rd(1'b0, v);
    chk(v == rxv, "R7", "external received byte", v, rxv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pinmux();
    t_int(3'b000, 1'b0, 1'b0, 8'hA5, 8'h3C);
    t_int(3'b011, 1'b1, 1'b0, 8'h81, 8'hD2);
    t_int(3'b001, 1'b0, 1'b1, 8'h6E, 8'h59);
    t_int(3'b010, 1'b1, 1'b0, 8'h0F, 8'hF0);
    t_int(3'b110, 1'b0, 1'b0, 8'hC3, 8'h1B);
    t_int(3'b111, 1'b1, 1'b0, 8'h5A, 8'hE7);
    t_ext(1'b0, 8'h96, 8'h2D);
    t_ext(1'b1, 8'h71, 8'hB4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule